// File: doc/BRIEF.md
# Queued Full-Duplex SPI Master

This block is a full-duplex SPI master with a transmit queue and a receive queue. The host side is a register-style strobe interface. The host pushes bytes into the transmit queue and pops received bytes from the head of the receive queue. It holds a chip-select level and an enable level, and it reads queue levels, threshold requests and sticky overflow flags. While the enable is high and the transmit queue holds data, the serial engine sends bytes one after another with no idle clock between them. Each byte received on the serial input goes into the receive queue.

The serial clock rests low. Each bit lasts eight system clocks: four clocks low, then four clocks high. The input is captured on the rising edge, and the output moves on the falling edge, which is SPI mode 0. The chip-select output follows a host-held level and is never toggled by the engine itself. The threshold requests let software service the queues in batches and not byte by byte.

Top module: `spi_queued_master`

## Requirements
- R1: After reset, sclk and mosi are 0, csN is 1, both queues are empty with level 0, both overflow flags and busy are 0, txReq is 1 and rxReq is 0.
- R2: sclk is 0 whenever no frame is in progress. Within a frame, each bit spans 8 clocks: sclk is low for 4 clocks, then high for 4. mosi changes only when a frame is loaded or on a falling sclk edge, and miso is captured at the rising sclk edge.
- R3: Frames are 8 bits and go most significant bit first. The byte captured from miso is the byte presented on rxData once it reaches the head of the receive queue.
- R4: Every completed frame offers its captured byte to the receive queue on the clock where its last sclk falling edge occurs.
- R5: While enable is 1 and the transmit queue is not empty, the next frame is loaded on the same clock the previous one ends, leaving no idle sclk gap. When enable drops to 0, the frame in progress completes and no new frame is started.
- R6: Each queue holds 8 entries and reports level, full and empty. A push is accepted when the queue was not full before the clock edge, even if a pop happens on that same edge.
- R7: A txPush while the transmit queue is full is dropped and sets txOverflow. txOverflow stays set until ovfClear bit 0 is pulsed. A new overflow on the same clock as the clear wins.
- R8: A completed frame that finds the receive queue full is dropped and sets rxOverflow. rxOverflow stays set until ovfClear bit 1 is pulsed, and a new overflow on the same clock wins.
- R9: txReq is 1 when 4 or more transmit entries are free (txLevel at most 4). rxReq is 1 when rxLevel is at least 4.
- R10: csN equals the inverse of csAssert one clock later, and transfers never change it.
- R11: busy is 1 from the clock after a frame is loaded until the clock on which the last frame of a back-to-back run ends.
- R12: rxData shows the head of the receive queue without a pop. An rxPop on an empty queue is ignored, and the level stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new frames to start |
| csAssert | input | 1 | Host chip-select request (1 = select) |
| txPush | input | 1 | Push txData into the transmit queue |
| txData | input | 8 | Byte to queue for sending |
| rxPop | input | 1 | Remove the head of the receive queue |
| rxData | output | 8 | Head of the receive queue |
| ovfClear | input | 2 | Write-one clear: bit 0 transmit, bit 1 receive overflow |
| txFull | output | 1 | Transmit queue full |
| txEmpty | output | 1 | Transmit queue empty |
| txLevel | output | 4 | Transmit queue occupancy |
| txReq | output | 1 | Transmit service request |
| rxFull | output | 1 | Receive queue full |
| rxEmpty | output | 1 | Receive queue empty |
| rxLevel | output | 4 | Receive queue occupancy |
| rxReq | output | 1 | Receive service request |
| txOverflow | output | 1 | Sticky transmit overflow |
| rxOverflow | output | 1 | Sticky receive overflow |
| busy | output | 1 | Transfer run in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Active-low chip select |

## Verification
The assertions assume that inputs change only between rising clock edges and that miso is stable at the clock edge where sclk rises. The bench meets both conditions. It drives every host input on the falling system clock edge. Its loopback slave captures mosi on a rising sclk edge and moves miso only on a falling one. The overflow checks also assume the host may push into a full queue or pop an empty one at any time. The stimulus does both on purpose, and it keeps chip select asserted across every transfer so the slave shifts on each frame.

// File: rtl/spim_pkg.sv
package spim_pkg;
  // Per-cycle commands from the sequencer to the shift datapath
  typedef struct packed {
    logic loadTx;     // take the transmit head into the shifter
    logic sampleBit;  // rising sclk edge: capture miso
    logic shiftBit;   // falling sclk edge: present next bit
    logic frameDone;  // last falling edge of a frame
  } spimStrobes_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  parameter int THRESH = 4,
  parameter bit REQ_ON_FREE = 1'b1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             full,
  output logic             empty,
  output logic [LVL_W-1:0] level,
  output logic             req
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [LVL_W-1:0] count;
  logic doPush, doPop;

  assign full   = (count == LVL_W'(DEPTH));
  assign empty  = (count == '0);
  assign level  = count;
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign headData = store[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  generate
    if (REQ_ON_FREE) begin : g_reqFree
      assign req = (LVL_W'(DEPTH) - count) >= LVL_W'(THRESH);
    end else begin : g_reqFill
      assign req = count >= LVL_W'(THRESH);
    end
  endgenerate

  p_full_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (full && !pop) |=> $stable(level));
  p_empty_pop_ignored_r12: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !push) |=> empty);
  p_level_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    count <= LVL_W'(DEPTH));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int CLK_DIV = 8,
  parameter int FRAME_BITS = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         txEmpty,
  output spimStrobes_t strobes,
  output logic         sclk,
  output logic         busy
);
  localparam int DIV_W = $clog2(CLK_DIV);
  localparam int BIT_W = $clog2(FRAME_BITS);

  logic             active;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic canStart, halfPt, endPt, lastBit;

  assign canStart = enable && !txEmpty;
  assign halfPt   = (divCnt == DIV_W'(CLK_DIV / 2 - 1));
  assign endPt    = (divCnt == DIV_W'(CLK_DIV - 1));
  assign lastBit  = (bitCnt == BIT_W'(FRAME_BITS - 1));

  always_comb begin
    strobes.sampleBit = active && halfPt;
    strobes.shiftBit  = active && endPt && !lastBit;
    strobes.frameDone = active && endPt && lastBit;
    strobes.loadTx    = canStart && (!active || (endPt && lastBit));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
      sclk   <= 1'b0;
    end else begin
      if (strobes.loadTx) begin
        active <= 1'b1;
        divCnt <= '0;
        bitCnt <= '0;
        sclk   <= 1'b0;
      end else if (strobes.frameDone) begin
        active <= 1'b0;
        divCnt <= '0;
        sclk   <= 1'b0;
      end else if (active) begin
        divCnt <= endPt ? '0 : divCnt + 1'b1;
        if (endPt) bitCnt <= bitCnt + 1'b1;
        if (strobes.sampleBit) sclk <= 1'b1;
        else if (endPt) sclk <= 1'b0;
      end
    end
  end

  assign busy = active;

  p_sclk_idle_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk);
  p_strobes_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.sampleBit, strobes.shiftBit, strobes.frameDone}));
  p_gapless_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.frameDone && enable && !txEmpty) |=> (busy && !sclk));
  p_stop_after_frame_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.frameDone && !enable) |=> !busy);
endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  spimStrobes_t          strobes,
  input  logic [FRAME_BITS-1:0] txHead,
  input  logic                  miso,
  output logic                  mosi,
  output logic [FRAME_BITS-1:0] rxWord
);
  logic [FRAME_BITS-1:0] txShift;
  logic [FRAME_BITS-1:0] rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strobes.loadTx)         txShift <= txHead;
      else if (strobes.shiftBit)  txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
      else if (strobes.frameDone) txShift <= '0;
      if (strobes.sampleBit)      rxShift <= {rxShift[FRAME_BITS-2:0], miso};
    end
  end

  assign mosi   = txShift[FRAME_BITS-1];
  assign rxWord = rxShift;

  p_mosi_steady_at_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sampleBit |=> $stable(mosi));
endmodule

// File: rtl/spi_queued_master.sv
module spi_queued_master
  import spim_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int REQ_THRESH = 4,
  parameter int CLK_DIV = 8,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              csAssert,
  input  logic              txPush,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxPop,
  output logic [DATA_W-1:0] rxData,
  input  logic [1:0]        ovfClear,
  output logic              txFull,
  output logic              txEmpty,
  output logic [LVL_W-1:0]  txLevel,
  output logic              txReq,
  output logic              rxFull,
  output logic              rxEmpty,
  output logic [LVL_W-1:0]  rxLevel,
  output logic              rxReq,
  output logic              txOverflow,
  output logic              rxOverflow,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              csN
);
  spimStrobes_t      strobes;
  logic [DATA_W-1:0] txHead;
  logic [DATA_W-1:0] rxWord;

  spim_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH), .THRESH(REQ_THRESH), .REQ_ON_FREE(1'b1)) txFifo_i (
    .clk(clk), .rstN(rstN), .push(txPush), .pushData(txData), .pop(strobes.loadTx),
    .headData(txHead), .full(txFull), .empty(txEmpty), .level(txLevel), .req(txReq));

  spim_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH), .THRESH(REQ_THRESH), .REQ_ON_FREE(1'b0)) rxFifo_i (
    .clk(clk), .rstN(rstN), .push(strobes.frameDone), .pushData(rxWord), .pop(rxPop),
    .headData(rxData), .full(rxFull), .empty(rxEmpty), .level(rxLevel), .req(rxReq));

  spim_ctrl #(.CLK_DIV(CLK_DIV), .FRAME_BITS(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .txEmpty(txEmpty),
    .strobes(strobes), .sclk(sclk), .busy(busy));

  spim_datapath #(.FRAME_BITS(DATA_W)) datapath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .txHead(txHead),
    .miso(miso), .mosi(mosi), .rxWord(rxWord));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOverflow <= 1'b0;
      rxOverflow <= 1'b0;
      csN        <= 1'b1;
    end else begin
      csN <= !csAssert;
      if (txPush && txFull)            txOverflow <= 1'b1;
      else if (ovfClear[0])            txOverflow <= 1'b0;
      if (strobes.frameDone && rxFull) rxOverflow <= 1'b1;
      else if (ovfClear[1])            rxOverflow <= 1'b0;
    end
  end

  p_tx_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txOverflow && !ovfClear[0]) |=> txOverflow);
  p_rx_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxOverflow && !ovfClear[1]) |=> rxOverflow);
  p_full_push_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txPush && txFull) |=> txOverflow);
endmodule

// File: tb/spi_queued_master_tb.sv
module spi_queued_master_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, csAssert = 1'b0, txPush = 1'b0, rxPop = 1'b0;
  logic [7:0] txData = 8'h00;
  logic [1:0] ovfClear = 2'b00;
  logic [7:0] rxData;
  logic txFull, txEmpty, txReq, rxFull, rxEmpty, rxReq;
  logic [3:0] txLevel, rxLevel;
  logic txOverflow, rxOverflow, busy, sclk, mosi, miso, csN;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_queued_master dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .csAssert(csAssert),
    .txPush(txPush), .txData(txData), .rxPop(rxPop), .rxData(rxData),
    .ovfClear(ovfClear), .txFull(txFull), .txEmpty(txEmpty), .txLevel(txLevel),
    .txReq(txReq), .rxFull(rxFull), .rxEmpty(rxEmpty), .rxLevel(rxLevel),
    .rxReq(rxReq), .txOverflow(txOverflow), .rxOverflow(rxOverflow), .busy(busy),
    .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN));

  // Loopback slave: captures on rising sclk, shifts out on falling sclk,
  // so each frame returns the byte received in the frame before it.
  logic [7:0] slaveReg = 8'h3C;
  logic slaveCap = 1'b0;
  assign miso = slaveReg[7];
  always @(posedge sclk) if (!csN) slaveCap <= mosi;
  always @(negedge sclk) if (!csN) slaveReg <= {slaveReg[6:0], slaveCap};

  // Behavioural reference model, advanced on every rising clock
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  bit mActive = 0, mTxOvf = 0, mRxOvf = 0, mCsN = 1;
  int mCnt = 0;
  logic [7:0] mTx = 0, mRxCur = 0, mSlaveHold = 8'h3C;

  always @(posedge clk) begin
    if (!rstN) begin
      txq.delete(); rxq.delete();
      mActive = 0; mTxOvf = 0; mRxOvf = 0; mCsN = 1; mCnt = 0; mTx = 0;
    end else begin
      int preTx, preRx;
      bit fin, start;
      preTx = txq.size(); preRx = rxq.size();
      fin = mActive && (mCnt == 63);
      start = (!mActive || fin) && enable && (preTx > 0);
      if (ovfClear[1]) mRxOvf = 0;
      if (rxPop && preRx > 0) void'(rxq.pop_front());
      if (fin) begin
        if (preRx < 8) rxq.push_back(mRxCur); else mRxOvf = 1;
      end
      if (start) begin
        mTx = txq.pop_front();
        mRxCur = mSlaveHold; mSlaveHold = mTx;
        mActive = 1; mCnt = 0;
      end else if (fin) begin
        mActive = 0; mCnt = 0;
      end else if (mActive) mCnt++;
      if (ovfClear[0]) mTxOvf = 0;
      if (txPush) begin
        if (preTx < 8) txq.push_back(txData); else mTxOvf = 1;
      end
      mCsN = !csAssert;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Compare against the model on every falling clock edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit eSclk, eMosi;
      eSclk = mActive && ((mCnt % 8) >= 4);
      eMosi = mActive ? mTx[7 - mCnt / 8] : 1'b0;
      chk(sclk == eSclk, "R2 sclk", sclk, eSclk);
      chk(mosi == eMosi, "R3 mosi", mosi, eMosi);
      chk(busy == mActive, "R11 busy", busy, mActive);
      chk(txLevel == txq.size(), "R6 txLevel", txLevel, txq.size());
      chk(rxLevel == rxq.size(), "R4 rxLevel", rxLevel, rxq.size());
      chk(txFull == (txq.size() == 8) && txEmpty == (txq.size() == 0), "R6 tx flags", {txFull, txEmpty}, txq.size());
      chk(rxFull == (rxq.size() == 8) && rxEmpty == (rxq.size() == 0), "R6 rx flags", {rxFull, rxEmpty}, rxq.size());
      chk(txReq == (txq.size() <= 4), "R9 txReq", txReq, txq.size() <= 4);
      chk(rxReq == (rxq.size() >= 4), "R9 rxReq", rxReq, rxq.size() >= 4);
      chk(txOverflow == mTxOvf, "R7 txOverflow", txOverflow, mTxOvf);
      chk(rxOverflow == mRxOvf, "R8 rxOverflow", rxOverflow, mRxOvf);
      chk(csN == mCsN, "R10 csN", csN, mCsN);
      if (rxq.size() > 0) chk(rxData == rxq[0], "R12 rxData head", rxData, rxq[0]);
    end
  end

  task automatic finishRun();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cycles, 50000);
      finishRun();
    end
  end

  task automatic pushBytes(input logic [7:0] first, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); txPush = 1'b1; txData = first + 8'(i);
    end
    @(negedge clk); txPush = 1'b0;
  endtask

  task automatic popN(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rxPop = 1'b1;
    end
    @(negedge clk); rxPop = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy && (txEmpty || !enable)) break;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(sclk == 0 && mosi == 0 && csN == 1, "R1 serial idle", {sclk, mosi, csN}, 3'b001);
    chk(txEmpty && rxEmpty && txLevel == 0 && rxLevel == 0, "R1 queues empty", {txLevel, rxLevel}, 0);
    chk(!busy && !txOverflow && !rxOverflow && txReq && !rxReq, "R1 flags",
        {busy, txOverflow, rxOverflow, txReq, rxReq}, 5'b00010);

    csAssert = 1'b1;
    repeat (2) @(negedge clk);
    chk(csN == 0, "R10 csN asserted", csN, 0);

    // Short run of three frames
    enable = 1'b1;
    pushBytes(8'hA1, 3);
    waitIdle();
    chk(rxLevel == 3, "R4 three frames received", rxLevel, 3);
    chk(rxData == 8'h3C, "R3 first byte from slave", rxData, 8'h3C);
    popN(3);

    // Fill the transmit queue while stopped
    enable = 1'b0;
    pushBytes(8'h10, 10);
    chk(txFull && txLevel == 8, "R6 tx full at 8", txLevel, 8);
    chk(txOverflow, "R7 tx overflow set", txOverflow, 1);
    chk(!txReq, "R9 txReq low when full", txReq, 0);
    @(negedge clk); ovfClear = 2'b01; txPush = 1'b1; txData = 8'hEE;
    @(negedge clk); ovfClear = 2'b00; txPush = 1'b0;
    chk(txOverflow, "R7 set wins over clear", txOverflow, 1);
    @(negedge clk); ovfClear = 2'b01;
    @(negedge clk); ovfClear = 2'b00;
    chk(!txOverflow, "R7 tx overflow cleared", txOverflow, 0);

    // Back-to-back run that overfills the receive queue
    enable = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (txLevel <= 6) break;
    end
    chk(busy, "R11 busy during run", busy, 1);
    pushBytes(8'h40, 2);
    waitIdle();
    chk(rxLevel == 8 && rxReq, "R9 rx full raises request", rxLevel, 8);
    chk(rxOverflow, "R8 rx overflow set", rxOverflow, 1);
    chk(rxData == 8'hA3, "R3 head after run", rxData, 8'hA3);
    popN(8);
    popN(3);
    chk(rxLevel == 0 && rxEmpty, "R12 pop on empty ignored", rxLevel, 0);
    @(negedge clk); ovfClear = 2'b10;
    @(negedge clk); ovfClear = 2'b00;
    chk(!rxOverflow, "R8 rx overflow cleared", rxOverflow, 0);

    // Enable drop mid-frame: current frame completes, rest stays queued
    pushBytes(8'h55, 3);
    repeat (30) @(negedge clk);
    enable = 1'b0;
    waitIdle();
    chk(txLevel == 1 || txLevel == 2, "R5 stop leaves data queued", txLevel, 2);
    chk(!busy && !sclk, "R5 idle after stop", {busy, sclk}, 0);
    popN(rxLevel);

    csAssert = 1'b0;
    repeat (2) @(negedge clk);
    chk(csN == 1, "R10 csN released", csN, 1);
    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule